// File: doc/BRIEF.md
# Frozen-Angle Byte Reader

The block sits between a continuously updating 14-bit angle source and a host that reads through an 8-bit bus. A hold register normally follows the live angle on every clock. When the host pulls the inhibit input low, the register stops updating and keeps one value, so the host can read the upper and lower bytes of the same sample. The angle source keeps running the whole time. When inhibit returns high, the register follows the live angle again.

There are two independent read ports, A and B. Each port has an active-low high-byte enable and an active-low low-byte enable. A port drives its bus only while one of its enables is low. Otherwise it lowers its drive flag, which stands in for high impedance. Because the inhibit input arrives from outside the clock domain, it passes through a synchronizer before it controls the hold register.

Top module: `angle_byte_reader`

## Requirements
- R1: While reset is asserted, the hold register is zero and, with all enables high, both drive flags and both data buses are zero.
- R2: While inhibit is high, the hold register loads the live angle at every clock edge. A byte read after one edge shows the new angle.
- R3: While inhibit is low, later changes of the live angle do not affect any byte read on either port.
- R4: When inhibit returns high, tracking resumes. Three edges after the first edge that samples inhibit high, the reads show the current live angle.
- R5: With the high-byte enable low, the port drives angle bits [13:6] on data[7:0] and raises its drive flag.
- R6: With only the low-byte enable low, the port drives angle bits [5:0] on data[7:2], drives data[1:0] to zero, and raises its drive flag.
- R7: If both enables of a port are low, the port drives the high byte.
- R8: With both enables of a port high, its drive flag is low and its data is zero. Deasserting an enable releases the bus with no clock edge needed.
- R9: Ports A and B decode independently and can show different bytes at the same time.
- R10: The frozen value is the live angle present at the second clock edge, counting the first edge that samples inhibit low as edge one (SYNC_STAGES edges).

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| angle_i | input | 14 | Live angle from the tracker |
| inhibit_i | input | 1 | Low freezes the hold register (asynchronous) |
| msb_a_ni | input | 1 | Port A high-byte enable, active low |
| lsb_a_ni | input | 1 | Port A low-byte enable, active low |
| msb_b_ni | input | 1 | Port B high-byte enable, active low |
| lsb_b_ni | input | 1 | Port B low-byte enable, active low |
| data_a_o | output | 8 | Port A data |
| drive_a_o | output | 1 | Port A drive flag (low means high impedance) |
| data_b_o | output | 8 | Port B data |
| drive_b_o | output | 1 | Port B drive flag (low means high impedance) |

## Verification
A freeze that arrives while the live angle is still changing must be checked together with a byte read. The bench lowers inhibit and then changes the angle just after each of the next two edges. It expects the value set after the first edge, neither the earlier nor the later one, to appear on both bytes of both ports. A host read of one port that overlaps a read of the other port, or a release of inhibit, is judged against the byte mapping of that captured value.

// File: rtl/angle_reader_pkg.sv
package angle_reader_pkg;
  typedef enum logic [1:0] {
    BSEL_IDLE,
    BSEL_HI,
    BSEL_LO
  } bsel_e;
endpackage

// File: rtl/inhibit_sync.sv
module inhibit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  // reset to tracking so the register follows the angle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '1;
    else         stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/angle_hold.sv
module angle_hold #(
  parameter int ANGLE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               track_i,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic [ANGLE_W-1:0] hold_o
);
  logic [ANGLE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (track_i) hold_q <= angle_i;
  end

  assign hold_o = hold_q;

  assert_track_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_i |=> hold_q == $past(angle_i));

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_i |=> $stable(hold_q));
endmodule

// File: rtl/byte_port.sv
module byte_port
  import angle_reader_pkg::*;
#(
  parameter int ANGLE_W = 14,
  parameter int BYTE_W  = 8
) (
  input  logic [ANGLE_W-1:0] hold_i,
  input  logic               hi_ni,
  input  logic               lo_ni,
  output logic [BYTE_W-1:0]  data_o,
  output logic               drive_o
);
  localparam int LO_W  = ANGLE_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  bsel_e sel;

  // high byte wins when both enables are low
  always_comb begin
    sel = BSEL_IDLE;
    if (!hi_ni)      sel = BSEL_HI;
    else if (!lo_ni) sel = BSEL_LO;
  end

  always_comb begin
    unique case (sel)
      BSEL_HI: data_o = hold_i[ANGLE_W-1 -: BYTE_W];
      BSEL_LO: data_o = {hold_i[LO_W-1:0], {PAD_W{1'b0}}};
      default: data_o = '0;
    endcase
  end

  assign drive_o = (sel != BSEL_IDLE);
endmodule

// File: rtl/angle_byte_reader.sv
module angle_byte_reader #(
  parameter int ANGLE_W     = 14,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               inhibit_i,
  input  logic               msb_a_ni,
  input  logic               lsb_a_ni,
  input  logic               msb_b_ni,
  input  logic               lsb_b_ni,
  output logic [BYTE_W-1:0]  data_a_o,
  output logic               drive_a_o,
  output logic [BYTE_W-1:0]  data_b_o,
  output logic               drive_b_o
);
  localparam int NPORTS = 2;
  localparam int LO_W   = ANGLE_W - BYTE_W;

  logic               track;
  logic [ANGLE_W-1:0] hold;
  logic [NPORTS-1:0]  hi_n, lo_n, drv;
  logic [BYTE_W-1:0]  dat [NPORTS];

  inhibit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(inhibit_i), .sync_o(track)
  );

  angle_hold #(.ANGLE_W(ANGLE_W)) u_hold (
    .clk_i, .rst_ni, .track_i(track), .angle_i, .hold_o(hold)
  );

  assign hi_n = {msb_b_ni, msb_a_ni};
  assign lo_n = {lsb_b_ni, lsb_a_ni};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    byte_port #(.ANGLE_W(ANGLE_W), .BYTE_W(BYTE_W)) u_port (
      .hold_i(hold), .hi_ni(hi_n[p]), .lo_ni(lo_n[p]),
      .data_o(dat[p]), .drive_o(drv[p])
    );
  end

  assign data_a_o  = dat[0];
  assign drive_a_o = drv[0];
  assign data_b_o  = dat[1];
  assign drive_b_o = drv[1];

  assert_hi_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msb_a_ni |-> (drive_a_o && data_a_o == hold[ANGLE_W-1 -: BYTE_W]));

  assert_lo_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_b_ni && !lsb_b_ni) |-> (drive_b_o && data_b_o[BYTE_W-1 -: LO_W] == hold[LO_W-1:0]));

  assert_idle_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_a_ni && lsb_a_ni) |-> (!drive_a_o && data_a_o == '0));

  assert_idle_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_b_ni && lsb_b_ni) |-> (!drive_b_o && data_b_o == '0));
endmodule

// File: tb/tb_angle_byte_reader.sv
module tb_angle_byte_reader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [13:0] angle = '0;
  logic        inh = 1;
  logic        ma_n = 1, la_n = 1, mb_n = 1, lb_n = 1;
  logic [7:0]  da, db;
  logic        va, vb;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_byte_reader dut (
    .clk_i(clk), .rst_ni(rst_n), .angle_i(angle), .inhibit_i(inh),
    .msb_a_ni(ma_n), .lsb_a_ni(la_n), .msb_b_ni(mb_n), .lsb_b_ni(lb_n),
    .data_a_o(da), .drive_a_o(va), .data_b_o(db), .drive_b_o(vb)
  );

  function automatic logic [7:0] hi_b(input logic [13:0] a); return a[13:6]; endfunction
  function automatic logic [7:0] lo_b(input logic [13:0] a); return {a[5:0], 2'b00}; endfunction

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_en(input logic a_hi, a_lo, b_hi, b_lo);
    ma_n = a_hi; la_n = a_lo; mb_n = b_hi; lb_n = b_lo;
    #1;
  endtask

  // reads both bytes on both ports and compares to one angle value
  task automatic read_all(input string tag, input logic [13:0] a);
    set_en(0, 1, 1, 0);
    chk({tag, " A hi"}, {va, da}, {1'b1, hi_b(a)});
    chk({tag, " B lo"}, {vb, db}, {1'b1, lo_b(a)});
    set_en(1, 0, 0, 1);
    chk({tag, " A lo"}, {va, da}, {1'b1, lo_b(a)});
    chk({tag, " B hi"}, {vb, db}, {1'b1, hi_b(a)});
    set_en(1, 1, 1, 1);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 A idle", {va, da}, 9'h0);
    chk("R1 B idle", {vb, db}, 9'h0);
    set_en(0, 1, 0, 1);
    chk("R1 hold zero", {va, da}, {1'b1, 8'h00});
    set_en(1, 1, 1, 1);
    rst_n = 1;
  endtask

  task automatic t_track;
    angle = 14'h2A5C; tick();
    read_all("R2 R5 R6 R9 track", 14'h2A5C);
    angle = 14'h03F1; tick();
    read_all("R2 track2", 14'h03F1);
  endtask

  task automatic t_prio_idle;
    angle = 14'h1234; tick();
    set_en(0, 0, 1, 0);
    chk("R7 both low A", {va, da}, {1'b1, hi_b(14'h1234)});
    chk("R9 B lo while A hi", {vb, db}, {1'b1, lo_b(14'h1234)});
    set_en(1, 1, 1, 1);
    chk("R8 release A", {va, da}, 9'h0);
    chk("R8 release B", {vb, db}, 9'h0);
  endtask

  // R10: freeze captures the angle at edge SYNC_STAGES
  task automatic t_freeze_edge;
    angle = 14'h0AAA; inh = 0;
    tick();                       // edge 1 samples inhibit low
    angle = 14'h3C3C; tick();     // edge 2 loads this value
    angle = 14'h1555; tick();     // edge 3 held
    read_all("R10 capture", 14'h3C3C);
    angle = 14'h3FFF; tick(4);
    read_all("R3 ignore", 14'h3C3C);
  endtask

  task automatic t_release;
    angle = 14'h2001; inh = 1;
    tick(2);
    read_all("R3 still frozen", 14'h3C3C);
    tick();
    read_all("R4 resume", 14'h2001);
    angle = 14'h0042; tick();
    read_all("R4 follows", 14'h0042);
  endtask

  initial begin
    t_reset();
    tick(2);
    t_track();
    t_prio_idle();
    t_freeze_edge();
    t_release();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule